// File: doc/BRIEF.md
# Cascadable LCD Segment Data Latch

This block is the digital core of an 80-column segment driver for a dot-matrix LCD panel. A display controller streams one line of pixel data into it, either four bits per shift-clock falling edge on a parallel bus or one bit per falling edge on a serial pin. The data is packed into 4-bit groups, and an internal group counter picks the slot each group goes to in a first-stage row latch. A falling edge of the line-load strobe copies that row into a second-stage latch. The second-stage latch drives a 2-bit level code for every column. Each code comes from the latched bit, the frame alternation signal and a display-enable input.

Several instances can share one data stream. Each chip takes data only while its chip-disable input is low. Its cascade output stays high until it holds a full row of 80 bits, then drops low. That output feeds the chip-disable input of the next chip, so the next chip takes the rest of the stream. The load strobe rewinds every chip, so the next line starts again at the first chip.

The shift clock and the load strobe are sampled by the block's system clock. Edges are detected inside the block, so every register is in a single clock domain.

Top module: `lcd_seg_latch`

## Requirements
- R1: After the active-low reset, both row latches hold zeros and `cascade_out` is high. With `disp_en`=1 and `alt`=0, every column then shows code 1.
- R2: With `par_mode`=1, each shift-clock falling edge writes one 4-bit group. `par_data[0]`, `par_data[1]`, `par_data[2]` and `ser_data` go to columns 4g, 4g+1, 4g+2 and 4g+3 of group g. Groups fill in order from g=0.
- R3: With `par_mode`=0, each shift-clock falling edge takes one bit from `ser_data`. The first bit of a group lands on column 4g and the fourth bit on column 4g+3. A group is written only when its fourth bit arrives.
- R4: When a serial line ends with fewer than four bits in an unfinished group, those bits never reach the columns. Those columns keep their previous first-stage contents.
- R5: While `chip_dis` is high, shift-clock edges change neither the first-stage latch nor the group position.
- R6: `cascade_out` is high while fewer than 20 groups have been written since the last load. It goes low once the 20th group is written.
- R7: After 20 groups, further shift-clock edges leave the first-stage latch unchanged.
- R8: Column outputs change only on a falling edge of `load_strb`. That edge copies the first-stage latch into the second-stage latch.
- R9: A falling edge of `load_strb` rewinds the group position and discards any partial serial group. `cascade_out` is then high, and the next written group goes to group 0. The first-stage latch itself keeps its contents.
- R10: With `disp_en`=1, the pair ({`alt`, bit}) selects the column code: 00 gives 1, 01 gives 0, 10 gives 2, 11 gives 3.
- R11: With `disp_en`=0, every column shows code 0, whatever its data and `alt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all other inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Data shift clock, acts on falling edge |
| load_strb | input | 1 | Line-load strobe, acts on falling edge |
| chip_dis | input | 1 | High: ignore shift clocks |
| par_mode | input | 1 | 1: 4-bit parallel input, 0: serial input |
| par_data | input | 3 | Low three bits of a parallel group |
| ser_data | input | 1 | Serial data, or bit 3 of a parallel group |
| alt | input | 1 | Frame alternation signal |
| disp_en | input | 1 | 0 forces every column to code 0 |
| cascade_out | output | 1 | High while this chip still needs data |
| drive_lvl | output | 160 | Column codes, column k in bits [2k+1:2k] |

## Verification
Some properties hold on every cycle, and the assertions check these. The group counter never passes 20. A disabled or full chip leaves its first-stage row untouched. The second-stage row moves only on a load edge. A load edge always raises the cascade output. A low display-enable forces all codes to 0.

Other behaviour needs the directed scenarios of the bench. These cover the column order of parallel and serial bits and the dropping of a trailing partial serial group. They also cover the rewind to group 0 after a load, and the full code table under both alternation phases.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

    // 2-bit column drive codes
    typedef enum logic [1:0] {
        LVL_IDLE    = 2'd0,  // blank / selected-positive level
        LVL_UNSEL_P = 2'd1,  // non-selected, positive phase
        LVL_UNSEL_N = 2'd2,  // non-selected, negative phase
        LVL_SEL_N   = 2'd3   // selected, negative phase
    } drive_lvl_e;

    function automatic drive_lvl_e pick_level(input logic en, input logic ph, input logic bit_v);
        drive_lvl_e r;
        if (!en) begin
            r = LVL_IDLE;
        end else begin
            case ({ph, bit_v})
                2'b00:   r = LVL_UNSEL_P;
                2'b01:   r = LVL_IDLE;
                2'b10:   r = LVL_UNSEL_N;
                default: r = LVL_SEL_N;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/lcd_fall_det.sv
module lcd_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~sig_in;
endmodule

// File: rtl/lcd_row_capture.sv
module lcd_row_capture #(
    parameter int NUM_OUT = 80,
    parameter int GRP_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_fall,
    input  logic               load_fall,
    input  logic               chip_dis,
    input  logic               par_mode,
    input  logic [GRP_W-1:0]   nib_in,
    input  logic               ser_bit,
    output logic [NUM_OUT-1:0] row_out,
    output logic               full
);
    localparam int NUM_GRP = NUM_OUT / GRP_W;
    localparam int CNT_W   = $clog2(NUM_GRP + 1);
    localparam int IDX_W   = (GRP_W > 1) ? $clog2(GRP_W) : 1;

    typedef struct packed {
        logic [NUM_OUT-1:0] row;
        logic [CNT_W-1:0]   grp;
        logic [IDX_W-1:0]   idx;
        logic [GRP_W-1:0]   acc;
    } cap_t;

    cap_t st_d, st_q;
    logic             wr_en;
    logic [GRP_W-1:0] wr_nib;

    always_comb begin
        st_d   = st_q;
        wr_en  = 1'b0;
        wr_nib = nib_in;
        if (load_fall) begin
            st_d.grp = '0;
            st_d.idx = '0;
            st_d.acc = '0;
        end else if (shift_fall && !chip_dis && !full) begin
            if (par_mode) begin
                wr_en  = 1'b1;
                wr_nib = nib_in;
            end else if (st_q.idx == IDX_W'(GRP_W - 1)) begin
                wr_en       = 1'b1;
                wr_nib      = st_q.acc;
                wr_nib[st_q.idx] = ser_bit;
                st_d.idx    = '0;
                st_d.acc    = '0;
            end else begin
                st_d.acc[st_q.idx] = ser_bit;
                st_d.idx           = st_q.idx + 1'b1;
            end
            if (wr_en) begin
                st_d.row[int'(st_q.grp) * GRP_W +: GRP_W] = wr_nib;
                st_d.grp = st_q.grp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full    = (st_q.grp == CNT_W'(NUM_GRP));
    assign row_out = st_q.row;

    assert_grp_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.grp <= CNT_W'(NUM_GRP));

    assert_full_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !load_fall) |=> $stable(st_q.row));

    assert_disabled_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_dis && !load_fall) |=> ($stable(st_q.row) && $stable(st_q.grp)));

    assert_load_rewinds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_fall |=> (st_q.grp == '0 && st_q.idx == '0));
endmodule

// File: rtl/lcd_row_hold.sv
module lcd_row_hold #(
    parameter int NUM_OUT = 80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_fall,
    input  logic [NUM_OUT-1:0] row_in,
    output logic [NUM_OUT-1:0] row_out
);
    logic [NUM_OUT-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load_fall) hold_d = row_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign row_out = hold_q;

    assert_hold_only_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_fall |=> $stable(hold_q));
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc #(
    parameter int NUM_OUT = 80
) (
    input  logic [NUM_OUT-1:0]   row_in,
    input  logic                 alt,
    input  logic                 disp_en,
    output logic [2*NUM_OUT-1:0] lvl_out
);
    import lcd_seg_pkg::*;

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_col
        always_comb begin
            lvl_out[2*k +: 2] = pick_level(disp_en, alt, row_in[k]);
        end
    end
endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch #(
    parameter int NUM_OUT = 80,
    parameter int GRP_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_clk,
    input  logic                 load_strb,
    input  logic                 chip_dis,
    input  logic                 par_mode,
    input  logic [GRP_W-2:0]     par_data,
    input  logic                 ser_data,
    input  logic                 alt,
    input  logic                 disp_en,
    output logic                 cascade_out,
    output logic [2*NUM_OUT-1:0] drive_lvl
);
    logic               shift_fall, load_fall, full;
    logic [NUM_OUT-1:0] cap_row, hold_row;

    lcd_fall_det u_shift_det (.clk(clk), .rst_n(rst_n), .sig_in(shift_clk), .fall(shift_fall));
    lcd_fall_det u_load_det  (.clk(clk), .rst_n(rst_n), .sig_in(load_strb), .fall(load_fall));

    lcd_row_capture #(.NUM_OUT(NUM_OUT), .GRP_W(GRP_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .shift_fall(shift_fall), .load_fall(load_fall),
        .chip_dis(chip_dis), .par_mode(par_mode), .nib_in({ser_data, par_data}),
        .ser_bit(ser_data), .row_out(cap_row), .full(full));

    lcd_row_hold #(.NUM_OUT(NUM_OUT)) u_hold (
        .clk(clk), .rst_n(rst_n), .load_fall(load_fall), .row_in(cap_row), .row_out(hold_row));

    lcd_level_enc #(.NUM_OUT(NUM_OUT)) u_enc (
        .row_in(hold_row), .alt(alt), .disp_en(disp_en), .lvl_out(drive_lvl));

    assign cascade_out = ~full;

    assert_blank_all_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (drive_lvl == '0));

    assert_cascade_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_fall |=> cascade_out);
endmodule

// File: tb/lcd_seg_latch_tb_top.sv
module lcd_seg_latch_tb_top;
    localparam int N = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_clk = 1'b1, load_strb = 1'b1, chip_dis = 1'b0, par_mode = 1'b1;
    logic [2:0] par_data = '0;
    logic ser_data = 1'b0, alt = 1'b0, disp_en = 1'b1;
    logic cascade_out;
    logic [2*N-1:0] drive_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [N-1:0] m_cap = '0;
    logic [N-1:0] m_hold = '0;
    int m_grp = 0;
    int m_idx = 0;
    logic [3:0] m_acc = '0;

    always #2.5 clk = ~clk;

    lcd_seg_latch dut_i (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .load_strb(load_strb),
        .chip_dis(chip_dis), .par_mode(par_mode), .par_data(par_data), .ser_data(ser_data),
        .alt(alt), .disp_en(disp_en), .cascade_out(cascade_out), .drive_lvl(drive_lvl));

    function automatic logic [2*N-1:0] exp_vec();
        logic [2*N-1:0] v;
        for (int k = 0; k < N; k++) begin
            if (!disp_en)                v[2*k +: 2] = 2'd0;
            else if (!alt && !m_hold[k]) v[2*k +: 2] = 2'd1;
            else if (!alt &&  m_hold[k]) v[2*k +: 2] = 2'd0;
            else if ( alt && !m_hold[k]) v[2*k +: 2] = 2'd2;
            else                         v[2*k +: 2] = 2'd3;
        end
        return v;
    endfunction

    task automatic check_out(input string tag);
        logic [2*N-1:0] e;
        e = exp_vec();
        checks++;
        if (drive_lvl !== e) begin
            errors++;
            $display("FAIL %s drive_lvl act=%h exp=%h", tag, drive_lvl, e);
        end
    endtask

    task automatic check_casc(input logic e, input string tag);
        checks++;
        if (cascade_out !== e) begin
            errors++;
            $display("FAIL %s cascade_out act=%b exp=%b", tag, cascade_out, e);
        end
    endtask

    task automatic shift_par(input logic [3:0] nib);
        par_mode = 1'b1;
        {ser_data, par_data} = nib;
        shift_clk = 1'b0;
        @(negedge clk);
        shift_clk = 1'b1;
        @(negedge clk);
        if (!chip_dis && m_grp < N/4) begin
            for (int i = 0; i < 4; i++) m_cap[m_grp*4 + i] = nib[i];
            m_grp++;
        end
    endtask

    task automatic shift_ser(input logic b);
        par_mode = 1'b0;
        ser_data = b;
        shift_clk = 1'b0;
        @(negedge clk);
        shift_clk = 1'b1;
        @(negedge clk);
        if (!chip_dis && m_grp < N/4) begin
            m_acc[m_idx] = b;
            if (m_idx == 3) begin
                for (int i = 0; i < 4; i++) m_cap[m_grp*4 + i] = m_acc[i];
                m_grp++;
                m_idx = 0;
                m_acc = '0;
            end else begin
                m_idx++;
            end
        end
    endtask

    task automatic pulse_load();
        load_strb = 1'b0;
        @(negedge clk);
        load_strb = 1'b1;
        @(negedge clk);
        m_hold = m_cap;
        m_grp = 0;
        m_idx = 0;
        m_acc = '0;
    endtask

    task automatic t_reset();
        check_casc(1'b1, "R1 reset cascade");
        check_out("R1 reset columns");
    endtask

    task automatic t_parallel_row();
        for (int g = 0; g < 19; g++) shift_par(4'((g*7 + 3) & 15));
        check_casc(1'b1, "R6 19 groups");
        shift_par(4'((19*7 + 3) & 15));
        check_casc(1'b0, "R6 20 groups");
        check_out("R8 no change before load");
        shift_par(4'hF);  // R7 saturation
        shift_par(4'h0);
        pulse_load();
        check_out("R2 R7 parallel row");
        check_casc(1'b1, "R9 cascade after load");
    endtask

    task automatic t_rewind();
        shift_par(4'hA);
        pulse_load();
        check_out("R9 next row starts at group 0");
    endtask

    task automatic t_serial();
        logic [9:0] bits;
        bits = 10'b00_1101_0110;
        bits[8] = ~m_cap[8];
        bits[9] = ~m_cap[9];
        for (int i = 0; i < 10; i++) shift_ser(bits[i]);
        pulse_load();
        check_out("R3 R4 serial with partial group");
        shift_ser(1'b1);
        shift_ser(1'b0);
        shift_ser(1'b0);
        shift_ser(1'b1);
        pulse_load();
        check_out("R4 partial discarded by load");
    endtask

    task automatic t_disabled();
        chip_dis = 1'b1;
        for (int i = 0; i < 5; i++) shift_par(4'h5 ^ 4'(i));
        check_casc(1'b1, "R5 disabled cascade");
        pulse_load();
        check_out("R5 disabled row unchanged");
        chip_dis = 1'b0;
        shift_par(4'h3);
        pulse_load();
        check_out("R5 group 0 after re-enable");
    endtask

    task automatic t_levels();
        alt = 1'b1;
        @(negedge clk);
        check_out("R10 alt high codes");
        alt = 1'b0;
        @(negedge clk);
        check_out("R10 alt low codes");
        disp_en = 1'b0;
        @(negedge clk);
        check_out("R11 blank alt low");
        alt = 1'b1;
        @(negedge clk);
        check_out("R11 blank alt high");
        disp_en = 1'b1;
        alt = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_parallel_row();
        t_rewind();
        t_serial();
        t_disabled();
        t_levels();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule